// File: doc/BRIEF.md
# Quarter-Rate IF-to-IQ Subsampler

This block turns a stream of real, signed converter samples taken from an intermediate-frequency receive path into paired baseband in-phase and quadrature samples. It relies on a fixed frequency plan: the IF is twice the symbol rate and the sample clock is eight times the symbol rate. That puts exactly four samples in every IF cycle. Because of this, mixing down to baseband needs neither a multiplier nor a numerically controlled oscillator. Each accepted sample is steered to I or Q in a four-step cycle, and the samples in the second half of every IF cycle are negated.

The block runs in the same clock domain as the downstream logic and accepts at most one sample per clock, qualified by a valid strobe. It issues an I/Q pair as soon as both halves of that pair have arrived, which gives four pairs per symbol. A decimate option keeps only the pair completed in the first half of each IF cycle. This yields the two-per-symbol (T/2) stream that a fractionally spaced equaliser expects. Every output pair carries a symbol-phase index. A resynchronise request realigns both the steering cycle and the index.

Top module: `if_iq_subsampler`

## Requirements
- R1: While reset (active-low, synchronous) is applied, and in the cycle after it, `out_vld` is 0. The routing phase and the symbol-phase index start at 0, so the first accepted sample after reset is used as a positive I sample.
- R2: The four accepted samples of each IF cycle are used, in routing phases 0, 1, 2 and 3, as +I, +Q, -I and -Q.
- R3: Negation saturates. An input of -2^(W-1) in phase 2 or 3 gives +2^(W-1)-1, and the same input in phase 0 or 1 passes through unchanged.
- R4: The routing phase advances only on cycles with `smp_vld` high. Idle cycles anywhere in the stream leave the output sequence unchanged.
- R5: In full-rate mode (`decim_en`=0), the cycle after each accepted phase-1 or phase-3 sample carries a one-cycle `out_vld` pulse. The pulse holds the I from the preceding phase-0 or phase-2 sample and the Q from that phase-1 or phase-3 sample. This gives four pairs per eight samples, and `out_vld` is never high otherwise.
- R6: With `decim_en`=1, only pairs completed by a phase-1 sample are issued, so there are two pairs per eight samples. Pairs completed in phase 3 are dropped.
- R7: `out_sym_idx` is 0 on the first issued pair after reset or resynchronisation. It then increases by one per issued pair and wraps to 0 after 3 in full-rate mode and after 1 in decimate mode (SAMPLES_PER_SYM=8).
- R8: A `resync` pulse makes the next accepted sample routing phase 0, and restarts the symbol-phase index at 0. This happens whether the pulse coincides with that sample or comes on an earlier idle cycle. A pulse on an idle cycle produces no output by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the converter and downstream logic |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_vld | input | 1 | Input sample strobe |
| smp_data | input | SAMPLE_W | Signed IF sample |
| resync | input | 1 | Realign routing phase and symbol index at the next sample |
| decim_en | input | 1 | 1: keep only first-half pairs (T/2 stream) |
| out_vld | output | 1 | Output pair strobe |
| out_i | output | SAMPLE_W | Signed in-phase sample |
| out_q | output | SAMPLE_W | Signed quadrature sample |
| out_sym_idx | output | $clog2(SAMPLES_PER_SYM/2) | Pair position within the symbol |

## Verification
The assertions run on every cycle and cover the following:
- the routing phase stays still on idle cycles;
- a resynchronising sample lands in phase 0;
- an output strobe follows only a quadrature sample, and only a phase-1 one in decimate mode;
- the symbol index stays inside the limit for the mode;
- the most negative input in phase 3 comes out as the most positive value.

Only the bench scenarios can show that the actual I and Q values follow the +I, +Q, -I, -Q order across bursts with and without gaps. They also show that the index wraps in the right sequence, and that a resync given on an idle cycle is held until the next sample without producing output.

// File: rtl/if_iq_pkg.sv
// Package: shared types for the quarter-rate IF-to-IQ subsampler.
// Assumes the sample clock is four times the IF, so one IF cycle spans
// four routing phases.
package if_iq_pkg;

    // Routing phase of a sample within one IF cycle.
    typedef enum logic [1:0] {
        PH_I_POS = 2'd0,
        PH_Q_POS = 2'd1,
        PH_I_NEG = 2'd2,
        PH_Q_NEG = 2'd3
    } route_ph_t;

    // True when the phase carries a quadrature sample.
    function automatic logic is_q_phase(route_ph_t ph);
        return ph[0];
    endfunction

    // True when the phase falls in the negated half of the IF cycle.
    function automatic logic is_neg_phase(route_ph_t ph);
        return ph[1];
    endfunction

endpackage

// File: rtl/iq_route_phase.sv
// Module: iq_route_phase
// Keeps the 2-bit routing phase that steers each accepted sample to
// +I, +Q, -I or -Q. The phase advances only on valid samples. A resync
// request is held until the next valid sample, and that sample is then
// forced to phase 0.
// Assumes at most one sample per clock.
module iq_route_phase
    import if_iq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      smp_vld,
    input  logic      resync,
    output route_ph_t ph_eff,
    output logic [1:0] ph_q,
    output logic      resync_hit
);

    logic rs_pend;
    logic rs_any;

    // Purpose: choose the phase that applies to the current sample.
    always_comb begin
        rs_any     = resync | rs_pend;
        resync_hit = smp_vld & rs_any;
        ph_eff     = rs_any ? PH_I_POS : route_ph_t'(ph_q);
    end

    // Purpose: advance the phase on each sample and hold pending resyncs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q    <= 2'd0;
            rs_pend <= 1'b0;
        end else begin
            if (smp_vld) begin
                ph_q    <= 2'(ph_eff) + 2'd1;
                rs_pend <= 1'b0;
            end else if (resync) begin
                rs_pend <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/iq_sat_neg.sv
// Module: iq_sat_neg
// Conditionally negates a signed sample. The most negative code is
// clamped to the most positive one instead of wrapping.
// Purely combinational.
module iq_sat_neg #(
    parameter int W = 12
) (
    input  logic signed [W-1:0] din,
    input  logic                neg,
    output logic signed [W-1:0] dout
);

    localparam logic signed [W-1:0] MIN_V = {1'b1, {(W-1){1'b0}}};
    localparam logic signed [W-1:0] MAX_V = {1'b0, {(W-1){1'b1}}};

    // Purpose: pass through or negate with clamping.
    always_comb begin
        if (!neg)
            dout = din;
        else if (din == MIN_V)
            dout = MAX_V;
        else
            dout = -din;
    end

endmodule

// File: rtl/iq_pair_builder.sv
// Module: iq_pair_builder
// Holds the sign-corrected I sample and signals a completed pair when the
// matching Q sample arrives. A Q sample with no I held is not paired.
// Assumes sign correction was already applied to val.
module iq_pair_builder
    import if_iq_pkg::*;
#(
    parameter int W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_vld,
    input  route_ph_t           ph_eff,
    input  logic signed [W-1:0] val,
    output logic                pair_fire,
    output logic                pair_late,
    output logic signed [W-1:0] i_held
);

    logic have_i;

    // Purpose: detect a completed I/Q pair on the current sample.
    always_comb begin
        pair_fire = smp_vld & is_q_phase(ph_eff) & have_i;
        pair_late = is_neg_phase(ph_eff);
    end

    // Purpose: capture I samples and track whether one is waiting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            i_held <= '0;
            have_i <= 1'b0;
        end else if (smp_vld) begin
            if (!is_q_phase(ph_eff)) begin
                i_held <= val;
                have_i <= 1'b1;
            end else begin
                have_i <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/iq_pair_out.sv
// Module: iq_pair_out
// Registers the output pairs, applies optional decimate-by-two (which
// keeps first-half pairs) and numbers the issued pairs within the symbol.
// Assumes PAIRS is even and at least 2.
module iq_pair_out #(
    parameter int W     = 12,
    parameter int PAIRS = 4,
    parameter int IW    = $clog2(PAIRS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pair_fire,
    input  logic                pair_late,
    input  logic signed [W-1:0] i_val,
    input  logic signed [W-1:0] q_val,
    input  logic                decim_en,
    input  logic                resync_hit,
    output logic                out_vld,
    output logic signed [W-1:0] out_i,
    output logic signed [W-1:0] out_q,
    output logic [IW-1:0]       out_sym_idx
);

    localparam logic [IW:0] LIM_FULL = (IW+1)'(PAIRS);
    localparam logic [IW:0] LIM_HALF = (IW+1)'(PAIRS / 2);

    logic [IW-1:0] cnt;
    logic [IW:0]   lim;
    logic [IW-1:0] cur_idx;
    logic [IW:0]   inc;
    logic [IW-1:0] nxt_idx;
    logic          keep;

    // Purpose: select kept pairs and compute the index and its successor.
    always_comb begin
        lim     = decim_en ? LIM_HALF : LIM_FULL;
        keep    = pair_fire & (~decim_en | ~pair_late);
        cur_idx = ({1'b0, cnt} >= lim) ? '0 : cnt;
        inc     = {1'b0, cur_idx} + 1'b1;
        nxt_idx = (inc >= lim) ? '0 : inc[IW-1:0];
    end

    // Purpose: register the output pair and step the symbol index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld     <= 1'b0;
            out_i       <= '0;
            out_q       <= '0;
            out_sym_idx <= '0;
            cnt         <= '0;
        end else begin
            out_vld <= keep;
            if (keep) begin
                out_i       <= i_val;
                out_q       <= q_val;
                out_sym_idx <= cur_idx;
                cnt         <= nxt_idx;
            end else if (resync_hit) begin
                cnt <= '0;
            end
        end
    end

endmodule

// File: rtl/if_iq_subsampler.sv
// Module: if_iq_subsampler (top)
// Mixes real IF samples to baseband I/Q by steering each sample in a
// repeating +I, +Q, -I, -Q order, then pairs the samples, optionally
// decimates to T/2 and tags each pair with its symbol phase.
// Assumes the sample clock is 4x the IF and 8x the symbol rate (default),
// with one shared clock and at most one sample per cycle.
module if_iq_subsampler
    import if_iq_pkg::*;
#(
    parameter int SAMPLE_W        = 12,
    parameter int SAMPLES_PER_SYM = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       smp_vld,
    input  logic signed [SAMPLE_W-1:0] smp_data,
    input  logic                       resync,
    input  logic                       decim_en,
    output logic                       out_vld,
    output logic signed [SAMPLE_W-1:0] out_i,
    output logic signed [SAMPLE_W-1:0] out_q,
    output logic [$clog2(SAMPLES_PER_SYM/2)-1:0] out_sym_idx
);

    localparam int PAIRS_PER_SYM = SAMPLES_PER_SYM / 2;
    localparam int IW            = $clog2(PAIRS_PER_SYM);

    route_ph_t                 ph_eff;
    logic [1:0]                ph_q;
    logic                      resync_hit;
    logic signed [SAMPLE_W-1:0] corr;
    logic                      pair_fire;
    logic                      pair_late;
    logic signed [SAMPLE_W-1:0] i_held;

    iq_route_phase u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_vld    (smp_vld),
        .resync     (resync),
        .ph_eff     (ph_eff),
        .ph_q       (ph_q),
        .resync_hit (resync_hit)
    );

    iq_sat_neg #(.W(SAMPLE_W)) u_neg (
        .din  (smp_data),
        .neg  (is_neg_phase(ph_eff)),
        .dout (corr)
    );

    iq_pair_builder #(.W(SAMPLE_W)) u_pair (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_vld   (smp_vld),
        .ph_eff    (ph_eff),
        .val       (corr),
        .pair_fire (pair_fire),
        .pair_late (pair_late),
        .i_held    (i_held)
    );

    iq_pair_out #(.W(SAMPLE_W), .PAIRS(PAIRS_PER_SYM), .IW(IW)) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .pair_fire   (pair_fire),
        .pair_late   (pair_late),
        .i_val       (i_held),
        .q_val       (corr),
        .decim_en    (decim_en),
        .resync_hit  (resync_hit),
        .out_vld     (out_vld),
        .out_i       (out_i),
        .out_q       (out_q),
        .out_sym_idx (out_sym_idx)
    );

endmodule

// File: rtl/if_iq_chk.sv
// Module: if_iq_chk
// Checker for if_iq_subsampler. It watches the ports together with the
// routing phase, and is attached through the bind statement below.
module if_iq_chk #(
    parameter int W     = 12,
    parameter int PAIRS = 4,
    parameter int IW    = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                smp_vld,
    input logic signed [W-1:0] smp_data,
    input logic                resync,
    input logic                decim_en,
    input logic                out_vld,
    input logic signed [W-1:0] out_q,
    input logic [IW-1:0]       out_sym_idx,
    input logic [1:0]          ph_eff,
    input logic [1:0]          ph_q
);

    localparam logic signed [W-1:0] MIN_V = {1'b1, {(W-1){1'b0}}};
    localparam logic signed [W-1:0] MAX_V = {1'b0, {(W-1){1'b1}}};

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !out_vld); // R1

    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> $stable(ph_q)); // R4

    AST_RESYNC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && resync) |=> (ph_q == 2'd1)); // R8

    AST_OUT_AFTER_Q: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> ($past(smp_vld) && $past(ph_eff[0]))); // R5

    AST_DECIM_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && $past(decim_en)) |-> ($past(ph_eff) == 2'd1)); // R6

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (int'(out_sym_idx) < ($past(decim_en) ? PAIRS / 2 : PAIRS))); // R7

    AST_NEG_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && $past(ph_eff) == 2'd3 && $past(smp_data) == MIN_V)
            |-> (out_q == MAX_V)); // R3

endmodule

bind if_iq_subsampler if_iq_chk #(
    .W     (SAMPLE_W),
    .PAIRS (PAIRS_PER_SYM),
    .IW    (IW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .smp_vld     (smp_vld),
    .smp_data    (smp_data),
    .resync      (resync),
    .decim_en    (decim_en),
    .out_vld     (out_vld),
    .out_q       (out_q),
    .out_sym_idx (out_sym_idx),
    .ph_eff      (ph_eff),
    .ph_q        (ph_q)
);

// File: tb/if_iq_subsampler_tb.sv
// Directed bench for if_iq_subsampler: one task per scenario.
module if_iq_subsampler_tb;

    localparam int W = 12;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic                rst_n    = 1'b0;
    logic                smp_vld  = 1'b0;
    logic signed [W-1:0] smp_data = '0;
    logic                resync   = 1'b0;
    logic                decim_en = 1'b0;
    logic                out_vld;
    logic signed [W-1:0] out_i;
    logic signed [W-1:0] out_q;
    logic [1:0]          out_sym_idx;

    if_iq_subsampler #(.SAMPLE_W(W), .SAMPLES_PER_SYM(8)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_vld     (smp_vld),
        .smp_data    (smp_data),
        .resync      (resync),
        .decim_en    (decim_en),
        .out_vld     (out_vld),
        .out_i       (out_i),
        .out_q       (out_q),
        .out_sym_idx (out_sym_idx)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic signed [W-1:0] cap_i [0:63];
    logic signed [W-1:0] cap_q [0:63];
    int                  cap_x [0:63];
    int                  n_cap = 0;
    logic signed [W-1:0] stim  [0:31];

    // Capture issued pairs away from the active edge.
    always @(negedge clk) begin
        if (rst_n && out_vld && n_cap < 64) begin
            cap_i[n_cap] = out_i;
            cap_q[n_cap] = out_q;
            cap_x[n_cap] = int'(out_sym_idx);
            n_cap = n_cap + 1;
        end
    end

    function automatic logic signed [W-1:0] neg_sat(logic signed [W-1:0] x);
        if (x == -12'sd2048) return 12'sd2047;
        return -x;
    endfunction

    task automatic check_eq(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic send(logic signed [W-1:0] x, int gap, bit rs);
        @(negedge clk);
        smp_vld  = 1'b1;
        smp_data = x;
        resync   = rs;
        @(negedge clk);
        smp_vld = 1'b0;
        resync  = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic pulse_resync();
        @(negedge clk);
        resync = 1'b1;
        @(negedge clk);
        resync = 1'b0;
    endtask

    // Send stim[0..n-1] from phase 0 / index 0 and compare with the model.
    task automatic play(string req, int n, int gap);
        int m   = 0;
        int cnt = 0;
        int lim = decim_en ? 2 : 4;
        n_cap = 0;
        for (int k = 0; k < n; k++) send(stim[k], gap, 1'b0);
        repeat (3) @(negedge clk);
        for (int k = 1; k < n; k += 2) begin
            int ph = k % 4;
            if (!decim_en || ph == 1) begin
                logic signed [W-1:0] ei;
                logic signed [W-1:0] eq;
                ei = (ph == 1) ? stim[k-1] : neg_sat(stim[k-1]);
                eq = (ph == 1) ? stim[k]   : neg_sat(stim[k]);
                if (m < n_cap) begin
                    check_eq(req, $sformatf("pair %0d I", m), int'(cap_i[m]), int'(ei));
                    check_eq(req, $sformatf("pair %0d Q", m), int'(cap_q[m]), int'(eq));
                    check_eq({req, " R7"}, $sformatf("pair %0d idx", m), cap_x[m], cnt);
                end
                cnt = (cnt + 1) % lim;
                m++;
            end
        end
        check_eq(req, "pair count", n_cap, m);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) begin
            @(negedge clk);
            check_eq("R1", "out_vld in reset", int'(out_vld), 0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1", "out_vld after reset", int'(out_vld), 0);
    endtask

    task automatic t_basic();
        for (int k = 0; k < 16; k++) stim[k] = W'(k * 37 - 300);
        play("R1 R2 R5", 16, 0);
    endtask

    task automatic t_gaps();
        pulse_resync();
        for (int k = 0; k < 12; k++) stim[k] = W'(500 - k * 91);
        play("R4", 12, 2);
    endtask

    task automatic t_sat();
        pulse_resync();
        for (int k = 0; k < 4; k++) stim[k] = -12'sd2048;
        stim[4] = 12'sd2047;
        stim[5] = -12'sd2047;
        stim[6] = 12'sd2047;
        stim[7] = -12'sd2047;
        play("R3", 8, 0);
    endtask

    task automatic t_decim();
        @(negedge clk);
        decim_en = 1'b1;
        pulse_resync();
        for (int k = 0; k < 16; k++) stim[k] = W'(k * 113 - 900);
        play("R6", 16, 1);
        @(negedge clk);
        decim_en = 1'b0;
    endtask

    task automatic t_resync();
        // Resync on an idle cycle mid-cycle: held, no output by itself.
        pulse_resync();
        n_cap = 0;
        send(12'sd11, 0, 1'b0);
        send(12'sd22, 0, 1'b0);
        send(12'sd33, 0, 1'b0);
        pulse_resync();
        repeat (3) @(negedge clk);
        check_eq("R8", "pairs before idle resync", n_cap, 1);
        for (int k = 0; k < 8; k++) stim[k] = W'(k * 7 + 40);
        play("R8", 8, 0);
        // Resync together with a sample in phase 3 position.
        pulse_resync();
        n_cap = 0;
        send(12'sd1, 0, 1'b0);
        send(12'sd2, 0, 1'b0);
        send(12'sd3, 0, 1'b0);
        send(12'sd77, 0, 1'b1);
        send(-12'sd88, 0, 1'b0);
        repeat (3) @(negedge clk);
        check_eq("R8", "pairs with coincident resync", n_cap, 2);
        check_eq("R8", "resync pair I", int'(cap_i[1]), 77);
        check_eq("R8", "resync pair Q", int'(cap_q[1]), -88);
        check_eq("R8", "resync pair idx", cap_x[1], 0);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_gaps();
        t_sat();
        t_decim();
        t_resync();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule